// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD registers. A single-cycle enable pulse, arriving once per second from an external prescaler, advances the seconds field. Each field's rollover carries into the next field in the same clock cycle: seconds, then minutes, then 24-hour hours, then both day-of-week and date, then month, then year. When the year wraps, a century flag in the hours byte can flip.

Every field sits in a byte whose bit layout matches its register-map image. A register interface can therefore hand a written byte straight to the matching load port and read the byte straight back from the output. The seconds byte also carries a run/stop control. The hours byte also carries the century-enable and century bits.

Top module: `bcd_rtc_chain`

## Requirements
- R1: Seconds (sec_o) and minutes (min_o) count 00 to 59 in BCD, with tens in bits 6:4 and units in bits 3:0. When seconds advance from 59 they become 00 and minutes advance in the same cycle.
- R2: Hours (hour_o bits 5:0) count 00 to 23 in BCD, with tens in bits 5:4. At 23:59:59 an advance gives 00:00:00 and carries one day.
- R3: Day of week (dow_o bits 2:0) advances once per day carry and goes from 07 back to 01.
- R4: Date (date_o bits 5:0, tens in 5:4) counts from 01 to the month's last day and then returns to 01 while the month advances. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months apart from 02. Month (mon_o bits 4:0, tens in bit 4) goes from 12 to 01 and carries one year.
- R5: With the default LEAP_EN=1, the last day of month 02 is 29 when the two-digit year is divisible by four, and 28 otherwise.
- R6: Year (year_o, tens in bits 7:4) counts 00 to 99 in BCD and wraps to 00.
- R7: hour_o bit 7 is century-enable and hour_o bit 6 is the century bit. On a year wrap from 99 to 00 with century-enable at 1, the century bit inverts. Otherwise it holds.
- R8: While sec_o bit 7 (the stop bit) is 1, tick_1hz is ignored and all time fields hold. While it is 0 the counter runs.
- R9: The time advances by exactly one second on each clock cycle in which tick_1hz is high, and never in any other cycle.
- R10: wr_en bit i loads wr_data into byte i, visible on the next clock. The byte indices are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. In a cycle with any write, tick_1hz is ignored.
- R11: Bits with no field read as 0 whatever was written. These are min_o bit 7, dow_o bits 7:3, date_o bits 7:6 and mon_o bits 7:5.
- R12: After reset, seconds, minutes, hours and year read 00, day of week, date and month read 01, and the stop, century-enable and century bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle once-per-second advance pulse |
| wr_en | input | 7 | Per-byte load strobes (0 sec … 6 year) |
| wr_data | input | 8 | Byte value for the strobed field |
| sec_o | output | 8 | Stop bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Century-enable, century bit and BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD date |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench drives each field to its boundary and checks the full carry ripple. The cases are 23:59:59 into a new day, the 30-day and 31-day month ends, February in a year divisible by four (including one with an odd tens digit, 12) and in one that is not, and December 31 of year 99 with century-enable both set and clear. A design with a wrong month table or a leap test on the binary value of the BCD byte would stop at the wrong date or skip a day. A design with a broken carry gate would leave minutes or the month behind. The bench also checks that the stop bit freezes the time, that a write in the same cycle as a tick suppresses the advance, and that masked bits read back as zero. A design that let the tick through would show an extra second.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_DOW  = 3'd3,
      FLD_DATE = 3'd4,
      FLD_MON  = 3'd5,
      FLD_YEAR = 3'd6
   } rtc_field_e;

   localparam int unsigned RTC_NUM_FIELDS = 7;

   // true when both nibbles are decimal digits
   function automatic logic bcd_ok(input logic [7:0] v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

   // decimal increment of a two-digit BCD byte (no wrap handling)
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // 10*t + u is divisible by 4 iff 2*t + u is: odd tens need units 2/6,
   // even tens need units 0/4/8
   function automatic logic bcd_div4(input logic [7:0] y);
      logic r;
      if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      return r;
   endfunction

   // last day of a BCD month
   function automatic logic [7:0] month_last(input logic [4:0] m, input logic leap);
      logic [7:0] r;
      case (m)
         5'h02:                      r = leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter int unsigned TENS_W = 3,
   parameter logic [7:0]  LO     = 8'h00,
   parameter logic [7:0]  HI     = 8'h59,
   parameter logic [7:0]  RST    = 8'h00,
   localparam int unsigned W     = 4 + TENS_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         last
);

   if (TENS_W < 1 || TENS_W > 4) begin : g_bad_tens
      $error("rtc_bcd_field: TENS_W must be 1..4");
   end
   if (!bcd_ok(LO) || !bcd_ok(HI) || !bcd_ok(RST)) begin : g_bad_bcd
      $error("rtc_bcd_field: LO, HI and RST must be BCD");
   end
   if (LO > HI || RST < LO || RST > HI) begin : g_bad_range
      $error("rtc_bcd_field: need LO <= RST <= HI");
   end
   if ((W < 8) && ((HI >> W) != 8'h00)) begin : g_bad_fit
      $error("rtc_bcd_field: HI does not fit the field width");
   end

   logic [W-1:0] cnt_q;
   logic [7:0]   cnt_ext;
   logic [7:0]   cnt_inc;

   always_comb begin
      cnt_ext         = '0;
      cnt_ext[W-1:0]  = cnt_q;
      cnt_inc         = bcd_next(cnt_ext);
   end

   // >= so an out-of-range load still wraps on the next step
   assign last  = (cnt_q >= HI[W-1:0]);
   assign value = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= RST[W-1:0];
      else if (load)    cnt_q <= load_val;
      else if (step)    cnt_q <= last ? LO[W-1:0] : cnt_inc[W-1:0];
   end

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter logic [7:0] RST_DATE  = 8'h01,
   parameter logic [7:0] RST_MONTH = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_step,
   input  logic       date_load,
   input  logic       mon_load,
   input  logic [7:0] load_val,
   input  logic       leap,
   output logic [5:0] date,
   output logic [4:0] month,
   output logic       year_step
);

   if (!bcd_ok(RST_DATE) || RST_DATE < 8'h01 || RST_DATE > 8'h28) begin : g_bad_date
      $error("rtc_calendar: RST_DATE must be BCD 01..28");
   end

   logic [5:0] date_q;
   logic [7:0] last_day;
   logic       date_last;
   logic       mon_step;
   logic       mon_last;
   logic [7:0] date_ext;
   logic [7:0] date_inc;

   assign last_day  = month_last(month, leap);
   assign date_last = (date_q >= last_day[5:0]);
   assign mon_step  = day_step & date_last;
   assign year_step = mon_step & mon_last;
   assign date_ext  = {2'b00, date_q};
   assign date_inc  = bcd_next(date_ext);
   assign date      = date_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         date_q <= RST_DATE[5:0];
      else if (date_load) date_q <= load_val[5:0];
      else if (day_step)  date_q <= date_last ? 6'h01 : date_inc[5:0];
   end

   rtc_bcd_field #(.TENS_W(1), .LO(8'h01), .HI(8'h12), .RST(RST_MONTH)) u_month (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mon_load),
      .load_val (load_val[4:0]),
      .step     (mon_step),
      .value    (month),
      .last     (mon_last)
   );

endmodule

// File: rtl/rtc_century_ctl.sv
`timescale 1ns/1ps
module rtc_century_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] load_bits,
   input  logic       year_wrap,
   output logic       cent_en,
   output logic       cent_bit
);

   logic en_q;
   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         bit_q <= 1'b0;
      end else if (load) begin
         en_q  <= load_bits[1];
         bit_q <= load_bits[0];
      end else if (year_wrap && en_q) begin
         bit_q <= ~bit_q;
      end
   end

   assign cent_en  = en_q;
   assign cent_bit = bit_q;

endmodule

// File: rtl/bcd_rtc_chain.sv
`timescale 1ns/1ps
module bcd_rtc_chain
   import rtc_pkg::*;
#(
   parameter bit         LEAP_EN   = 1'b1,
   parameter logic [7:0] RST_YEAR  = 8'h00,
   parameter logic [7:0] RST_MONTH = 8'h01,
   parameter logic [7:0] RST_DATE  = 8'h01,
   parameter logic [7:0] RST_DOW   = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic [6:0] wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] dow_o,
   output logic [7:0] date_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o
);

   localparam int unsigned NF = RTC_NUM_FIELDS;

   if (NF != 7) begin : g_bad_nf
      $error("bcd_rtc_chain: field count mismatch");
   end
   if (RST_DOW < 8'h01 || RST_DOW > 8'h07) begin : g_bad_dow
      $error("bcd_rtc_chain: RST_DOW must be 01..07");
   end
   if (RST_MONTH < 8'h01 || RST_MONTH > 8'h12) begin : g_bad_mon
      $error("bcd_rtc_chain: RST_MONTH must be 01..12");
   end

   logic       stop_q;
   logic       any_wr;
   logic       adv;
   logic [6:0] sec_q;
   logic [6:0] min_q;
   logic [5:0] hour_q;
   logic [4:0] dow_q;
   logic [5:0] date_q;
   logic [4:0] mon_q;
   logic [7:0] year_q;
   logic       sec_last, min_last, hour_last, dow_last, year_last;
   logic       sec_wrap, min_wrap, day_step, year_step, year_wrap;
   logic       leap;
   logic       cent_en, cent_bit;

   assign any_wr   = |wr_en;
   assign adv      = tick_1hz & ~stop_q & ~any_wr;
   assign sec_wrap = adv & sec_last;
   assign min_wrap = sec_wrap & min_last;
   assign day_step = min_wrap & hour_last;
   assign year_wrap = year_step & year_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stop_q <= 1'b0;
      else if (wr_en[int'(FLD_SEC)]) stop_q <= wr_data[7];
   end

   rtc_bcd_field #(.TENS_W(3), .LO(8'h00), .HI(8'h59), .RST(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_SEC)]), .load_val(wr_data[6:0]),
      .step(adv), .value(sec_q), .last(sec_last)
   );

   rtc_bcd_field #(.TENS_W(3), .LO(8'h00), .HI(8'h59), .RST(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_MIN)]), .load_val(wr_data[6:0]),
      .step(sec_wrap), .value(min_q), .last(min_last)
   );

   rtc_bcd_field #(.TENS_W(2), .LO(8'h00), .HI(8'h23), .RST(8'h00)) u_hour (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_HOUR)]), .load_val(wr_data[5:0]),
      .step(min_wrap), .value(hour_q), .last(hour_last)
   );

   rtc_century_ctl u_cent (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_HOUR)]), .load_bits(wr_data[7:6]),
      .year_wrap(year_wrap), .cent_en(cent_en), .cent_bit(cent_bit)
   );

   rtc_bcd_field #(.TENS_W(1), .LO(8'h01), .HI(8'h07), .RST(RST_DOW)) u_dow (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_DOW)]), .load_val({2'b00, wr_data[2:0]}),
      .step(day_step), .value(dow_q), .last(dow_last)
   );

   rtc_calendar #(.RST_DATE(RST_DATE), .RST_MONTH(RST_MONTH)) u_cal (
      .clk(clk), .rst_n(rst_n),
      .day_step(day_step),
      .date_load(wr_en[int'(FLD_DATE)]), .mon_load(wr_en[int'(FLD_MON)]),
      .load_val(wr_data), .leap(leap),
      .date(date_q), .month(mon_q), .year_step(year_step)
   );

   rtc_bcd_field #(.TENS_W(4), .LO(8'h00), .HI(8'h99), .RST(RST_YEAR)) u_year (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en[int'(FLD_YEAR)]), .load_val(wr_data),
      .step(year_step), .value(year_q), .last(year_last)
   );

   if (LEAP_EN) begin : g_leap
      assign leap = bcd_div4(year_q);
   end else begin : g_no_leap
      assign leap = 1'b0;
   end

   // dow wrap needs no carry out; the flag only feeds the field itself
   logic unused_dow_last;
   assign unused_dow_last = dow_last;

   assign sec_o  = {stop_q, sec_q};
   assign min_o  = {1'b0, min_q};
   assign hour_o = {cent_en, cent_bit, hour_q};
   assign dow_o  = {3'b000, dow_q};
   assign date_o = {2'b00, date_q};
   assign mon_o  = {3'b000, mon_q};
   assign year_o = year_q;

endmodule

// File: rtl/rtc_chain_chk.sv
`timescale 1ns/1ps
module rtc_chain_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1hz,
   input logic [6:0] wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] dow_o,
   input logic [7:0] date_o,
   input logic [7:0] mon_o,
   input logic [7:0] year_o
);

   logic [55:0] snap;
   assign snap = {sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o};

   AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !sec_o[7] && wr_en == 7'd0 && sec_o[6:0] == 7'h59)
      |=> (sec_o[6:0] == 7'h00 && min_o != $past(min_o))); // R1

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_o[7] && wr_en == 7'd0) |=> $stable(snap)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1hz && wr_en == 7'd0) |=> $stable(snap)); // R9

   AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 7'd0 && !hour_o[7]) |=> $stable(hour_o[7:6])); // R7

   AST_YEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[6] |=> (year_o == $past(wr_data))); // R10

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (min_o[7] == 1'b0 && dow_o[7:3] == 5'd0 && date_o[7:6] == 2'd0 && mon_o[7:5] == 3'd0)); // R11

endmodule

bind bcd_rtc_chain rtc_chain_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_data(wr_data),
   .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
   .date_o(date_o), .mon_o(mon_o), .year_o(year_o)
);

// File: tb/bcd_rtc_chain_tb.sv
`timescale 1ns/1ps
module bcd_rtc_chain_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic [6:0] wr_en = 7'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bcd_rtc_chain u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_data(wr_data),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
      .date_o(date_o), .mon_o(mon_o), .year_o(year_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      wr_en   = 7'd1 << idx;
      wr_data = d;
      @(negedge clk);
      wr_en   = 7'd0;
   endtask

   task automatic set_all(input logic [7:0] y, mo, da, dw, h, mi, s);
      wr(6, y); wr(5, mo); wr(4, da); wr(3, dw); wr(2, h); wr(1, mi); wr(0, s);
   endtask

   task automatic tick_once();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic t_reset();
      check("R12 sec",   sec_o,  8'h00);
      check("R12 min",   min_o,  8'h00);
      check("R12 hour",  hour_o, 8'h00);
      check("R12 dow",   dow_o,  8'h01);
      check("R12 date",  date_o, 8'h01);
      check("R12 month", mon_o,  8'h01);
      check("R12 year",  year_o, 8'h00);
   endtask

   task automatic t_sec_min();
      set_all(8'h20, 8'h06, 8'h10, 8'h03, 8'h08, 8'h14, 8'h58);
      tick_once();
      check("R9 sec +1", sec_o, 8'h59);
      check("R9 min hold", min_o, 8'h14);
      tick_once();
      check("R1 sec wrap", sec_o, 8'h00);
      check("R1 min carry", min_o, 8'h15);
      wr(0, 8'h09);
      tick_once();
      check("R1 units to tens", sec_o, 8'h10);
   endtask

   task automatic t_day_roll();
      set_all(8'h20, 8'h03, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R2 sec", sec_o, 8'h00);
      check("R2 min", min_o, 8'h00);
      check("R2 hour wrap", hour_o, 8'h00);
      check("R3 dow 7->1", dow_o, 8'h01);
      check("R2 date carry", date_o, 8'h16);
      set_all(8'h20, 8'h03, 8'h15, 8'h02, 8'h09, 8'h59, 8'h59);
      tick_once();
      check("R2 hour 09->10", hour_o, 8'h10);
      check("R3 dow hold", dow_o, 8'h02);
   endtask

   task automatic t_month_len();
      set_all(8'h21, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R4 30-day date", date_o, 8'h01);
      check("R4 30-day month", mon_o, 8'h05);
      set_all(8'h21, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R4 31-day date", date_o, 8'h31);
      check("R4 31-day month", mon_o, 8'h05);
      set_all(8'h24, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R4 dec date", date_o, 8'h01);
      check("R4 dec month", mon_o, 8'h01);
      check("R4 year carry", year_o, 8'h25);
   endtask

   task automatic t_feb();
      set_all(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R5 non-leap date", date_o, 8'h01);
      check("R5 non-leap month", mon_o, 8'h03);
      set_all(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R5 leap 29", date_o, 8'h29);
      check("R5 leap month", mon_o, 8'h02);
      set_all(8'h12, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_once();
      check("R5 leap odd tens", date_o, 8'h29);
      wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
      tick_once();
      check("R5 leap end date", date_o, 8'h01);
      check("R5 leap end month", mon_o, 8'h03);
   endtask

   task automatic t_century();
      set_all(8'h99, 8'h12, 8'h31, 8'h04, 8'hA3, 8'h59, 8'h59);
      tick_once();
      check("R6 year wrap", year_o, 8'h00);
      check("R7 century flip", hour_o, 8'hC0);
      set_all(8'h99, 8'h12, 8'h31, 8'h04, 8'h63, 8'h59, 8'h59);
      tick_once();
      check("R7 century held", hour_o, 8'h40);
      check("R6 year wrap 2", year_o, 8'h00);
   endtask

   task automatic t_stop();
      set_all(8'h30, 8'h07, 8'h04, 8'h05, 8'h12, 8'h34, 8'h90);
      tick_once(); tick_once(); tick_once();
      check("R8 stopped sec", sec_o, 8'h90);
      check("R8 stopped min", min_o, 8'h34);
      wr(0, 8'h10);
      tick_once();
      check("R8 running", sec_o, 8'h11);
   endtask

   task automatic t_idle_and_collide();
      set_all(8'h30, 8'h07, 8'h04, 8'h05, 8'h12, 8'h34, 8'h10);
      repeat (20) @(negedge clk);
      check("R9 idle hold", sec_o, 8'h10);
      @(negedge clk);
      tick_1hz = 1'b1;
      wr_en    = 7'b0000010;
      wr_data  = 8'h30;
      @(negedge clk);
      tick_1hz = 1'b0;
      wr_en    = 7'd0;
      check("R10 write loads", min_o, 8'h30);
      check("R10 tick ignored", sec_o, 8'h10);
   endtask

   task automatic t_mask();
      wr(1, 8'hA5);
      check("R11 min bit7", min_o, 8'h25);
      wr(3, 8'hFD);
      check("R11 dow", dow_o, 8'h05);
      wr(4, 8'hD5);
      check("R11 date", date_o, 8'h15);
      wr(5, 8'hE9);
      check("R11 month", mon_o, 8'h09);
      wr(6, 8'h87);
      check("R10 year load", year_o, 8'h87);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sec_min();
      t_day_roll();
      t_month_len();
      t_feb();
      t_century();
      t_stop();
      t_idle_and_collide();
      t_mask();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule